// File: doc/BRIEF.md
# Vector Swizzle Unit with Constant Fill

The unit rearranges one sub-vector of up to four integer elements per accepted request. Each destination lane is steered by its own 3-bit selector field. That field either copies one lane of the current source sub-vector or inserts one of four fixed constants that suit the element width. An immediate variant takes a compact 8-bit selector that holds four 2-bit lane indices and never yields a constant.

The result is registered and appears one cycle after the request. A malformed request sets an illegal-instruction flag instead of writing the destination. A malformed request is one with selector bits set beyond the fields in use, a lane index outside the source sub-vector, or an unsupported element type. A small counter tags each result with its position in the outer vector loop and marks the final one. The caller steps through a vector by presenting one source group per vector index.

Top module: `swz_unit`

## Requirements
- R1: In register mode, destination lane i is driven by the field in selector bits [3i+2:3i]. When bit 2 of the field is 0, the lane takes source lane number field[1:0].
- R2: When bit 2 of a field is 1, the lane takes a constant chosen by field[1:0]: 0 gives zero, 1 gives one, 2 gives all ones of the element width, and 3 gives the largest positive signed value of the element width.
- R3: The element type code is 0 for 8-bit, 1 for 16-bit and 2 for 32-bit. Copied lanes are cut to the element width and zero-extended to 32 bits.
- R4: The destination length code is the length minus one. Destination lanes at or above the length come out as zero.
- R5: In register mode, any selector bit at position 3*(destination length) or higher raises the trap.
- R6: The source length code is the length minus one. A copy field whose index is at or above the source length raises the trap. A constant field never traps on the source length.
- R7: Element type code 3 raises the trap.
- R8: On a trap, trap_o is 1 and dst_o keeps its previous value. A clean request sets trap_o to 0.
- R9: valid_o is high exactly in the cycle after an edge where valid_i was high. trap_o, dst_o, idx_o and last_o change only on such requests.
- R10: In immediate mode, destination lane i takes source lane sel_i[2i+1:2i]. Selector bits 15:8 are ignored, and so are fields of lanes at or above the destination length.
- R11: idx_o gives the result's vector index. It counts 0 to vl_i-1 over consecutive requests, trapped ones included, and then wraps. last_o is 1 when idx_o equals vl_i-1.
- R12: While rst_ni is low, valid_o, trap_o, dst_o, idx_o, last_o and the counter are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request present this cycle |
| imm_mode_i | input | 1 | 1: immediate selector form, 0: register selector form |
| sel_i | input | SEL_W | Packed selector word |
| src_len_i | input | 2 | Source sub-vector length minus one |
| dst_len_i | input | 2 | Destination sub-vector length minus one |
| etype_i | input | 2 | Element type code |
| vl_i | input | IDX_W | Outer vector length |
| src_i | input | LANES*ELEM_W | Source group, lane 0 in the low bits |
| valid_o | output | 1 | Result present |
| trap_o | output | 1 | Illegal-instruction flag for the result |
| dst_o | output | LANES*ELEM_W | Destination group, lane 0 in the low bits |
| idx_o | output | IDX_W | Vector index of the result |
| last_o | output | 1 | Result is the final index of the vector |

## Verification
The stimulus table covers several selector patterns. A full lane reversal shows whether field positions are decoded in the right order. An all-constant word checks each table entry at 32 bits. Mixed copy and constant words at 8 and 16 bits show whether masking and constant width follow the element type, and a broadcast shows repeated reads of a single lane. Trap cases each break exactly one rule: a stray upper bit, a lane past the source length, the reserved type, and an immediate index past the source length. Each is followed by a check that the previous destination survived. Immediate words carry garbage in their ignored bits, and a constant is selected with a one-lane source, so that any leakage of ignored state shows up in the result.

// File: rtl/swz_pkg.sv
package swz_pkg;
  typedef enum logic [1:0] {
    ET_B8  = 2'd0,
    ET_H16 = 2'd1,
    ET_W32 = 2'd2,
    ET_RSV = 2'd3
  } etype_e;

  localparam int unsigned FLD_W     = 3;
  localparam int unsigned IMM_W     = 8;
  localparam int unsigned IMM_FLD_W = 2;
  localparam int unsigned N_CONST   = 4;
endpackage

// File: rtl/swz_consts.sv
module swz_consts import swz_pkg::*; #(
  parameter int unsigned ELEM_W = 32
) (
  input  etype_e                               etype_i,
  output logic [ELEM_W-1:0]                    mask_o,
  output logic [N_CONST-1:0][ELEM_W-1:0]       tbl_o
);
  int unsigned width;

  always_comb begin
    unique case (etype_i)
      ET_B8:   width = 8;
      ET_H16:  width = 16;
      ET_W32:  width = 32;
      default: width = 0;
    endcase
    for (int b = 0; b < ELEM_W; b++) mask_o[b] = (b < int'(width));
  end

  // zero, one, all ones, max positive signed
  always_comb begin
    tbl_o[0] = '0;
    tbl_o[1] = (width != 0) ? ELEM_W'(1) : '0;
    tbl_o[2] = mask_o;
    tbl_o[3] = mask_o >> 1;
  end
endmodule

// File: rtl/swz_sel_dec.sv
module swz_sel_dec import swz_pkg::*; #(
  parameter int unsigned SEL_W = 16,
  parameter int unsigned LANES = 4,
  parameter int unsigned LEN_W = 2
) (
  input  logic                          imm_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [LEN_W-1:0]              dst_len_i,
  output logic [LANES-1:0][FLD_W-1:0]   fld_o,
  output logic [LANES-1:0]              act_o,
  output logic                          upper_bad_o
);
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      act_o[i] = (i <= int'(dst_len_i));
      fld_o[i] = '0;
      for (int b = 0; b < int'(FLD_W); b++) begin
        if (imm_i) begin
          // immediate fields are 2-bit lane indices, never constants
          if (b < int'(IMM_FLD_W) && (IMM_FLD_W*i + b) < IMM_W && (IMM_FLD_W*i + b) < SEL_W)
            fld_o[i][b] = sel_i[IMM_FLD_W*i + b];
        end else if ((FLD_W*i + b) < SEL_W) begin
          fld_o[i][b] = sel_i[FLD_W*i + b];
        end
      end
    end
  end

  always_comb begin
    upper_bad_o = 1'b0;
    for (int b = 0; b < SEL_W; b++)
      if (!imm_i && sel_i[b] && b >= int'(FLD_W) * (int'(dst_len_i) + 1))
        upper_bad_o = 1'b1;
  end
endmodule

// File: rtl/swz_lane.sv
module swz_lane import swz_pkg::*; #(
  parameter int unsigned ELEM_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LEN_W  = 2
) (
  input  logic [FLD_W-1:0]                 fld_i,
  input  logic                             act_i,
  input  logic [LEN_W-1:0]                 src_len_i,
  input  logic [LANES-1:0][ELEM_W-1:0]     src_i,
  input  logic [N_CONST-1:0][ELEM_W-1:0]   tbl_i,
  input  logic [ELEM_W-1:0]                mask_i,
  output logic [ELEM_W-1:0]                data_o,
  output logic                             bad_o
);
  logic [FLD_W-2:0] idx;
  logic [ELEM_W-1:0] pick;

  assign idx = fld_i[FLD_W-2:0];

  always_comb begin
    pick = '0;
    for (int l = 0; l < LANES; l++)
      if (int'(idx) == l) pick = src_i[l];
  end

  always_comb begin
    data_o = '0;
    bad_o  = 1'b0;
    if (act_i) begin
      if (fld_i[FLD_W-1]) begin
        data_o = tbl_i[idx];
      end else begin
        bad_o  = int'(idx) > int'(src_len_i);
        data_o = pick & mask_i;
      end
    end
  end
endmodule

// File: rtl/swz_unit.sv
module swz_unit import swz_pkg::*; #(
  parameter int unsigned ELEM_W = 32,
  parameter int unsigned LANES  = 4,
  parameter int unsigned SEL_W  = 16,
  parameter int unsigned IDX_W  = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        valid_i,
  input  logic                        imm_mode_i,
  input  logic [SEL_W-1:0]            sel_i,
  input  logic [$clog2(LANES)-1:0]    src_len_i,
  input  logic [$clog2(LANES)-1:0]    dst_len_i,
  input  logic [1:0]                  etype_i,
  input  logic [IDX_W-1:0]            vl_i,
  input  logic [LANES*ELEM_W-1:0]     src_i,
  output logic                        valid_o,
  output logic                        trap_o,
  output logic [LANES*ELEM_W-1:0]     dst_o,
  output logic [IDX_W-1:0]            idx_o,
  output logic                        last_o
);
  localparam int unsigned LEN_W  = $clog2(LANES);
  localparam int unsigned DATA_W = LANES * ELEM_W;

  etype_e                              etype;
  logic [LANES-1:0][ELEM_W-1:0]        src_lanes;
  logic [LANES-1:0][ELEM_W-1:0]        dst_lanes;
  logic [N_CONST-1:0][ELEM_W-1:0]      tbl;
  logic [ELEM_W-1:0]                   mask;
  logic [LANES-1:0][FLD_W-1:0]         fld;
  logic [LANES-1:0]                    act;
  logic [LANES-1:0]                    lane_bad;
  logic                                upper_bad;
  logic                                trap_c;
  logic [IDX_W-1:0]                    cnt_q, cnt_nxt, vl_last;

  assign etype     = etype_e'(etype_i);
  assign src_lanes = src_i;

  swz_consts #(.ELEM_W(ELEM_W)) u_consts (
    .etype_i (etype),
    .mask_o  (mask),
    .tbl_o   (tbl)
  );

  swz_sel_dec #(.SEL_W(SEL_W), .LANES(LANES), .LEN_W(LEN_W)) u_dec (
    .imm_i       (imm_mode_i),
    .sel_i       (sel_i),
    .dst_len_i   (dst_len_i),
    .fld_o       (fld),
    .act_o       (act),
    .upper_bad_o (upper_bad)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    swz_lane #(.ELEM_W(ELEM_W), .LANES(LANES), .LEN_W(LEN_W)) u_lane (
      .fld_i     (fld[g]),
      .act_i     (act[g]),
      .src_len_i (src_len_i),
      .src_i     (src_lanes),
      .tbl_i     (tbl),
      .mask_i    (mask),
      .data_o    (dst_lanes[g]),
      .bad_o     (lane_bad[g])
    );
  end

  assign trap_c  = upper_bad | (|lane_bad) | (etype == ET_RSV);
  assign vl_last = vl_i - IDX_W'(1);
  assign cnt_nxt = (cnt_q == vl_last) ? '0 : cnt_q + IDX_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      trap_o  <= 1'b0;
      dst_o   <= '0;
      idx_o   <= '0;
      last_o  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        trap_o <= trap_c;
        if (!trap_c) dst_o <= dst_lanes;
        idx_o  <= cnt_q;
        last_o <= (cnt_q == vl_last);
        cnt_q  <= cnt_nxt;
      end
    end
  end

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  p_valid_drop_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  p_trap_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && trap_o) |-> $stable(dst_o));

  p_idle_lanes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !trap_c && dst_len_i == '0) |=> (dst_o[DATA_W-1:ELEM_W] == '0));

  localparam logic [DATA_W-1:0] HI8_MASK = {LANES{{(ELEM_W-8){1'b1}}, 8'h00}};
  p_narrow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !trap_c && etype == ET_B8) |=> ((dst_o & HI8_MASK) == '0));

  if (SEL_W > FLD_W * LANES) begin : g_top_bit_chk
    p_upper_trap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && !imm_mode_i && sel_i[SEL_W-1]) |=> trap_o);
  end
endmodule

// File: tb/swz_unit_test.sv
module swz_unit_test;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 128;

  typedef struct packed {
    logic          imm;
    logic [15:0]   sel;
    logic [1:0]    sl;
    logic [1:0]    dl;
    logic [1:0]    et;
    logic          trap;
    logic [DW-1:0] dst;
  } vec_t;

  localparam logic [DW-1:0] SRC = 128'h55667788_8899AABB_11223344_A1B2C3D4;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 16'h0053, 2'd3, 2'd3, 2'd2, 1'b0, 128'hA1B2C3D4_11223344_8899AABB_55667788}, // R1 reverse
    '{1'b0, 16'h0FAC, 2'd3, 2'd3, 2'd2, 1'b0, 128'h7FFFFFFF_FFFFFFFF_00000001_00000000}, // R2 consts
    '{1'b0, 16'h0EB0, 2'd3, 2'd3, 2'd0, 1'b0, 128'h0000007F_000000BB_000000FF_000000D4}, // R3 8-bit
    '{1'b0, 16'h0029, 2'd1, 2'd1, 2'd1, 1'b0, 128'h00000000_00000000_00000001_00003344}, // R4 16-bit
    '{1'b0, 16'h0000, 2'd0, 2'd3, 2'd1, 1'b0, 128'h0000C3D4_0000C3D4_0000C3D4_0000C3D4}, // R1 bcast
    '{1'b0, 16'h0040, 2'd1, 2'd1, 2'd1, 1'b1, 128'h0000C3D4_0000C3D4_0000C3D4_0000C3D4}, // R5
    '{1'b0, 16'h0002, 2'd1, 2'd0, 2'd1, 1'b1, 128'h0000C3D4_0000C3D4_0000C3D4_0000C3D4}, // R6
    '{1'b0, 16'h8000, 2'd3, 2'd3, 2'd2, 1'b1, 128'h0000C3D4_0000C3D4_0000C3D4_0000C3D4}, // R5 top
    '{1'b0, 16'h0000, 2'd3, 2'd3, 2'd3, 1'b1, 128'h0000C3D4_0000C3D4_0000C3D4_0000C3D4}, // R7
    '{1'b1, 16'hFF1B, 2'd3, 2'd3, 2'd2, 1'b0, 128'hA1B2C3D4_11223344_8899AABB_55667788}, // R10
    '{1'b1, 16'h00F4, 2'd1, 2'd1, 2'd0, 1'b0, 128'h00000000_00000000_00000044_000000D4}, // R10 ign
    '{1'b1, 16'h0001, 2'd0, 2'd0, 2'd2, 1'b1, 128'h00000000_00000000_00000044_000000D4}, // R6 imm
    '{1'b0, 16'h0006, 2'd0, 2'd0, 2'd2, 1'b0, 128'h00000000_00000000_00000000_FFFFFFFF}  // R6 const
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic          imm_mode_i = 1'b0;
  logic [15:0]   sel_i = '0;
  logic [1:0]    src_len_i = '0;
  logic [1:0]    dst_len_i = '0;
  logic [1:0]    etype_i = '0;
  logic [7:0]    vl_i = 8'd5;
  logic [DW-1:0] src_i = SRC;
  logic          valid_o, trap_o, last_o;
  logic [DW-1:0] dst_o;
  logic [7:0]    idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  swz_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid_i), .imm_mode_i(imm_mode_i),
    .sel_i(sel_i), .src_len_i(src_len_i), .dst_len_i(dst_len_i), .etype_i(etype_i),
    .vl_i(vl_i), .src_i(src_i), .valid_o(valid_o), .trap_o(trap_o), .dst_o(dst_o),
    .idx_o(idx_o), .last_o(last_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    imm_mode_i = v.imm; sel_i = v.sel; src_len_i = v.sl;
    dst_len_i = v.dl; etype_i = v.et; valid_i = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 valid", DW'(valid_o), '0);
    chk("R12 dst", dst_o, '0);
    chk("R12 idx/last/trap", DW'({idx_o, last_o, trap_o}), '0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      drive(VECS[k]);
      @(negedge clk);
      valid_i = 1'b0;
      chk("R9 valid", DW'(valid_o), DW'(1));
      chk($sformatf("R8 trap v%0d", k), DW'(trap_o), DW'(VECS[k].trap));
      chk($sformatf("R1 dst v%0d", k), dst_o, VECS[k].dst);
      chk("R11 idx", DW'(idx_o), DW'(k % 5));
      chk("R11 last", DW'(last_o), DW'((k % 5) == 4));
    end

    // R9: idle cycle drops valid and holds result
    @(negedge clk);
    chk("R9 idle valid", DW'(valid_o), '0);
    chk("R9 idle dst", dst_o, VECS[NV-1].dst);

    // R12 reset mid-run clears the counter
    rst_ni = 1'b0;
    #1;
    chk("R12 async dst", dst_o, '0);
    @(negedge clk);
    rst_ni = 1'b1;
    vl_i = 8'd1;
    for (int k = 0; k < 2; k++) begin
      drive(VECS[0]);
      @(negedge clk);
      valid_i = 1'b0;
      chk("R11 vl1 idx", DW'(idx_o), '0);
      chk("R11 vl1 last", DW'(last_o), DW'(1));
      chk("R1 after reset", dst_o, VECS[0].dst);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule